// File: doc/BRIEF.md
# SPI Clock-Polarity Bridge with Target Decode

This glue block sits between a host serial port whose shift clock rests high and SPI peripherals that expect a clock resting low. The host provides four things: a raw shift clock, an arm line and an active-low select line, all sampled in a faster system clock domain, plus a five-bit target address. The block produces a gated shift clock, `sck_o`, that stays low while the bridge is disarmed. After arming, `sck_o` stays low until the raw clock has been seen low at least once. From then on it follows the raw clock until the arm line drops. With this behaviour a mode-3 master behaves as a mode-0 master.

To use real mode-3 timing, the host keeps select deasserted, raises the arm line and clocks out one dummy byte, which arms the bridge. It then asserts select. The raw clock, idle-high level included, now reaches the output unchanged. The address decode uses its top bit as a select enable. When that bit is set and select is asserted, exactly one of the active-low target selects goes low, picked by the low four bits. MOSI and MISO pass straight through with no logic.

Top module: `spi_mode_bridge`

## Requirements
- R1: After reset `sck_o` is 0 and every bit of `tgt_sel_n_o` is 1.
- R2: While the synchronized arm line is low, `sck_o` is 0 and the armed state is clear.
- R3: After the arm line rises with the raw clock high, `sck_o` stays 0 until the raw clock has been sampled low.
- R4: Once armed, the bridge stays armed whatever the raw clock does, and `sck_o` equals the synchronized raw clock, 3 system clocks after the input (2 synchronizer stages plus 1 output register).
- R5: Dropping the arm line forces `sck_o` low at once. After re-arming, a fresh raw-clock low is needed before `sck_o` can go high.
- R6: If the bridge is armed by a dummy byte while select is high and select is then asserted, the raw clock's idle-high level appears on `sck_o` (mode-3 pass-through).
- R7: With select low and `addr_i[4]` = 1, bit `addr_i[3:0]` of `tgt_sel_n_o` is 0 and all other bits are 1. At most one bit is ever 0.
- R8: With `addr_i[4]` = 0, or with select high, all bits of `tgt_sel_n_o` are 1.
- R9: `mosi_o` equals `mosi_i` and `miso_o` equals `miso_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the raw shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_sck_i | input | 1 | Host shift clock, idles high |
| arm_i | input | 1 | Clock arm line from host |
| sel_n_i | input | 1 | Host slave select, active low |
| addr_i | input | 5 | Target address: bit 4 enable, bits 3:0 index |
| mosi_i | input | 1 | Host data out |
| miso_i | input | 1 | Selected target data out |
| sck_o | output | 1 | Gated shift clock to targets |
| mosi_o | output | 1 | Data to targets |
| miso_o | output | 1 | Data to host |
| tgt_sel_n_o | output | 16 | Per-target selects, active low |

## Verification
The bench uses the default parameters: two synchronizer stages and four index bits. With these values all sixteen targets can be addressed, as well as the enable-clear case and the full three-cycle path from the raw clock to `sck_o`. Each stimulus step is held for longer than that path, so the expected clock and select levels can be taken from a small reference of the arm, raw-clock and address rules. The dummy-byte arming sequence and re-arming after a disarm both appear as explicit step sequences.

// File: rtl/spi_mode_bridge.sv
module spi_mode_bridge #(
  parameter int SYNC_STAGES = 2,
  parameter int TGT_BITS    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       raw_sck_i,
  input  logic                       arm_i,
  input  logic                       sel_n_i,
  input  logic [TGT_BITS:0]          addr_i,
  input  logic                       mosi_i,
  input  logic                       miso_i,
  output logic                       sck_o,
  output logic                       mosi_o,
  output logic                       miso_o,
  output logic [(1<<TGT_BITS)-1:0]   tgt_sel_n_o
);
  localparam int NUM_TGT = 1 << TGT_BITS;
  localparam int TOP     = SYNC_STAGES - 1;

  logic [TOP:0] raw_sync, arm_sync, sel_sync;
  logic raw_s, arm_s, sel_n_s;
  logic armed;
  logic sck_q;
  logic [NUM_TGT-1:0] hot, sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_sync <= '1;
      arm_sync <= '0;
      sel_sync <= '1;
    end else begin
      raw_sync <= {raw_sync[TOP-1:0], raw_sck_i};
      arm_sync <= {arm_sync[TOP-1:0], arm_i};
      sel_sync <= {sel_sync[TOP-1:0], sel_n_i};
    end
  end

  assign raw_s   = raw_sync[TOP];
  assign arm_s   = arm_sync[TOP];
  assign sel_n_s = sel_sync[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (!arm_s) armed <= 1'b0;
    else if (!raw_s) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= arm_s & raw_s & armed;
  end

  always_comb begin
    hot = '0;
    if (!sel_n_s && addr_i[TGT_BITS]) hot[addr_i[TGT_BITS-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= hot;
  end

  assign sck_o       = sck_q;
  assign tgt_sel_n_o = ~sel_q;
  assign mosi_o      = mosi_i;
  assign miso_o      = miso_i;
endmodule

module spi_mode_bridge_chk #(
  parameter int NUM_TGT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arm_s,
  input logic               raw_s,
  input logic               sel_n_s,
  input logic               armed,
  input logic               sck_o,
  input logic               mosi_i,
  input logic               mosi_o,
  input logic               miso_i,
  input logic               miso_o,
  input logic [NUM_TGT-1:0] tgt_sel_n_o
);
  AST_DISARM_LOW:   assert property (@(posedge clk) disable iff (!rst_n) !arm_s |=> (!sck_o && !armed)); // R2
  AST_WAIT_FALL:    assert property (@(posedge clk) disable iff (!rst_n) (arm_s && raw_s && !armed) |=> !sck_o); // R3
  AST_ARMED_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (armed && arm_s) |=> armed); // R4
  AST_FOLLOW_RAW:   assert property (@(posedge clk) disable iff (!rst_n) (armed && arm_s) |=> (sck_o == $past(raw_s))); // R4
  AST_DISARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $fell(arm_s) |=> !armed); // R5
  AST_ONE_TARGET:   assert property (@(posedge clk) disable iff (!rst_n) $countones(~tgt_sel_n_o) <= 1); // R7
  AST_NO_SELECT:    assert property (@(posedge clk) disable iff (!rst_n) sel_n_s |=> (&tgt_sel_n_o)); // R8
  AST_DATA_THRU:    assert property (@(posedge clk) disable iff (!rst_n) (mosi_o == mosi_i) && (miso_o == miso_i)); // R9
endmodule

bind spi_mode_bridge spi_mode_bridge_chk #(.NUM_TGT(NUM_TGT)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_s(arm_s), .raw_s(raw_s), .sel_n_s(sel_n_s),
  .armed(armed), .sck_o(sck_o), .mosi_i(mosi_i), .mosi_o(mosi_o),
  .miso_i(miso_i), .miso_o(miso_o), .tgt_sel_n_o(tgt_sel_n_o)
);

// File: tb/spi_mode_bridge_bench.sv
module spi_mode_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic raw_sck_i = 1'b1, arm_i = 1'b0, sel_n_i = 1'b1;
  logic [4:0] addr_i = '0;
  logic mosi_i = 1'b0, miso_i = 1'b0;
  logic sck_o, mosi_o, miso_o;
  logic [15:0] tgt_sel_n_o;

  int checks = 0, errors = 0;
  bit model_armed = 1'b0;

  typedef struct {
    logic        sck;
    logic [15:0] sel;
    string       req;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mode_bridge u_spi_mode_bridge (
    .clk(clk), .rst_n(rst_n), .raw_sck_i(raw_sck_i), .arm_i(arm_i),
    .sel_n_i(sel_n_i), .addr_i(addr_i), .mosi_i(mosi_i), .miso_i(miso_i),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_o(miso_o), .tgt_sel_n_o(tgt_sel_n_o)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      check(sck_o === it.sck, {it.req, " sck"}, {15'd0, sck_o}, {15'd0, it.sck});
      check(tgt_sel_n_o === it.sel, {it.req, " sel"}, tgt_sel_n_o, it.sel);
    end
  end

  task automatic step(input logic raw, input logic arm, input logic seln, input logic [4:0] addr, input string req);
    item_t it;
    @(negedge clk);
    raw_sck_i = raw; arm_i = arm; sel_n_i = seln; addr_i = addr;
    if (!arm) model_armed = 1'b0;
    else if (!raw) model_armed = 1'b1;
    it.sck = arm & raw & model_armed;
    it.sel = '1;
    if (!seln && addr[4]) it.sel[addr[3:0]] = 1'b0;
    it.req = req;
    repeat (SETTLE) @(posedge clk);
    q.push_back(it);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(sck_o === 1'b0, "R1 reset sck", {15'd0, sck_o}, 16'd0);
    check(tgt_sel_n_o === 16'hFFFF, "R1 reset sel", tgt_sel_n_o, 16'hFFFF);
    rst_n = 1'b1;

    step(1, 0, 1, 5'h00, "R2 disarmed raw high");
    step(0, 0, 1, 5'h00, "R2 disarmed raw low");
    step(1, 0, 1, 5'h00, "R2 disarmed raw high again");
    step(1, 1, 1, 5'h00, "R3 armed waiting for fall");
    step(1, 1, 1, 5'h00, "R3 still waiting");
    step(0, 1, 0, 5'h12, "R4 first fall");
    step(1, 1, 0, 5'h12, "R4 first rise");
    step(0, 1, 0, 5'h12, "R4 follow low");
    step(1, 1, 0, 5'h12, "R4 follow high");
    step(1, 0, 0, 5'h12, "R5 disarm drops clock");
    step(1, 0, 1, 5'h12, "R5 deselect after disarm");
    step(1, 1, 1, 5'h00, "R5 rearm needs new fall");
    step(0, 1, 1, 5'h00, "R5 new fall");
    step(1, 1, 1, 5'h00, "R5 rearmed follows");
    step(1, 0, 1, 5'h00, "R6 reset for mode3");
    step(1, 1, 1, 5'h00, "R6 arm with select high");
    for (int b = 0; b < 8; b++) begin
      step(0, 1, 1, 5'h00, "R6 dummy low");
      step(1, 1, 1, 5'h00, "R6 dummy high");
    end
    step(1, 1, 0, 5'h13, "R6 idle high passes");
    step(0, 1, 0, 5'h13, "R6 pass low");
    step(1, 1, 0, 5'h13, "R6 pass high");
    step(1, 1, 0, 5'h03, "R8 enable clear");
    step(1, 1, 0, 5'h1F, "R7 target 15");
    step(1, 1, 0, 5'h10, "R7 target 0");
    step(1, 1, 1, 5'h1A, "R8 select high");
    step(1, 0, 0, 5'h17, "R7 target 7");
    step(1, 0, 1, 5'h00, "R8 idle");

    mosi_i = 1'b1; miso_i = 1'b0; #1;
    check(mosi_o === 1'b1 && miso_o === 1'b0, "R9 pass 10", {14'd0, mosi_o, miso_o}, 16'h2);
    mosi_i = 1'b0; miso_i = 1'b1; #1;
    check(mosi_o === 1'b0 && miso_o === 1'b1, "R9 pass 01", {14'd0, mosi_o, miso_o}, 16'h1);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule